// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the programming face of a four-channel DMA controller, seen by a host over a byte-wide I/O bus with a 4-bit register address. Each channel keeps a 16-bit current address, a 16-bit current count and a saved base copy of both, plus a mode byte. The block also holds one mask bit per channel and a set of terminal-count flags. The 16-bit values travel through a single byte-wide port per register. A shared low/high byte pointer decides which half each access reaches. Software resets that pointer by writing any value to a dedicated address.

The transfer engine is outside this block. It reports each completed transfer on a channel through a one-cycle strobe. For each accepted strobe the block steps the channel's address, lowers its count, and detects the terminal transfer. On the terminal transfer it either reloads the channel from its base copy (auto-initialize) or masks the channel. Request lines from devices come in and leave gated by the masks. The mode fields a transfer engine needs are driven out as ports.

Top module: `dmac_regfront`

## Requirements
- R1: Register addresses 2n and 2n+1 (n = 0..3) hold channel n's address and count. Each is 16 bits, reached as a low byte then a high byte at the same address. One shared byte pointer (0 = low byte) selects the half and flips after every read or write to any of the eight addresses 0x0 to 0x7. A write loads the selected byte into both the base and the current copy. A read returns the selected byte of the current copy.
- R2: A write of any data to address 0xB returns the byte pointer to the low byte.
- R3: The count holds the transfer length minus one. An accepted done strobe does the following. If the count is nonzero, it lowers the count by one and steps the address by one, down when mode bit 4 is set and up otherwise. If the count is zero, the transfer is terminal: term_cnt pulses in that same cycle. Without auto-initialize, the count then wraps to 0xFFFF and the address still steps.
- R4: With auto-initialize (mode bit 3) set, a terminal transfer reloads the current address and current count from the base copies. The count then reads back as the value last programmed.
- R5: A read of address 0x8 returns the terminal-count flags in bits 3:0 and the live request inputs in bits 7:4. The read clears the flags at the end of that cycle. A terminal transfer in the same cycle leaves its flag set.
- R6: A write to address 0x9 uses bits 1:0 as the channel and bit 2 as the new mask value (1 = masked). It changes no other channel's mask.
- R7: A write to address 0xC loads all four masks from data bits 3:0, bit i for channel i. After reset, all channels are masked. After reset, the byte pointer is low and all counters, modes and flags are zero.
- R8: A write to address 0xA uses bits 1:0 as the channel and stores the rest into that channel only. Bit 2 is the direction (1 = memory to device). Bit 3 enables auto-initialize and bit 4 sets downward address stepping. Bits 6:5 set the request kind: 00 demand, 01 single, 10 cascade, 11 single. Direction and kind drive chan_dir and chan_kind.
- R9: A done strobe has no effect on a channel that is masked or set to cascade. req_out is each request input ANDed with the inverse of its mask.
- R10: A terminal transfer without auto-initialize sets that channel's mask bit. This takes priority over a mask write in the same cycle.
- R11: A bus write to a channel's address or count register in the same cycle as that channel's done strobe discards the strobe.
- R12: io_rdata is zero whenever no read is in progress and for reads of addresses 0x9 to 0xF. When io_wr and io_rd are both high, only the write takes effect. Writes to 0x8 and 0xD to 0xF change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 4 | Register address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| dreq | input | 4 | Device request lines |
| xfer_done | input | 4 | Per-channel transfer-completed strobes |
| req_out | output | 4 | Unmasked requests |
| term_cnt | output | 4 | Terminal transfer pulse, same cycle as the strobe |
| chan_mask | output | 4 | Current mask bits |
| chan_dir | output | 4 | Direction bit per channel |
| chan_kind | output | 8 | Request kind, two bits per channel |

## Verification
Some properties hold on every cycle and are checked continuously:
- The byte pointer always flips after a register access.
- The byte pointer returns to low after a clear.
- A non-auto terminal transfer always wraps the count to 0xFFFF.
- An auto-initialize terminal transfer always restores the base copies.
- A cascade channel never moves its counters.
- A non-auto terminal transfer always leaves its channel masked.
- A status read always empties the flags, except for flags newly set in the same cycle.

Other behaviours show up only across whole scenarios:
- A 16-bit value assembled from two bytes reads back correctly.
- Masking, mode or pointer state survives sequences of unrelated accesses.
- A write that collides with a done strobe discards the strobe.

A constrained-random run against a bench model exposes these.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam logic [3:0] A_STAT   = 4'h8;
  localparam logic [3:0] A_SMASK  = 4'h9;
  localparam logic [3:0] A_MODE   = 4'hA;
  localparam logic [3:0] A_CLRPTR = 4'hB;
  localparam logic [3:0] A_AMASK  = 4'hC;

  localparam int SMASK_VAL_BIT = 2;

  typedef enum logic [1:0] {
    KIND_DEMAND = 2'b00,
    KIND_SINGLE = 2'b01,
    KIND_CASC   = 2'b10,
    KIND_ALT    = 2'b11
  } req_kind_t;

  typedef struct packed {
    req_kind_t kind;      // data bits 6:5
    logic      down;      // data bit 4
    logic      autoinit;  // data bit 3
    logic      dir;       // data bit 2
  } mode_t;

endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic clr_i,
  output logic ptr_o
);

  logic ptr_q, ptr_d, ptr_en;

  always_comb begin
    ptr_en = acc_i | clr_i;
    ptr_d  = clr_i ? 1'b0 : ~ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  // R1: every register access flips the half selector
  p_ptr_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i) |=> (ptr_q != $past(ptr_q)));

  // R2: clearing returns to the low byte
  p_ptr_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ptr_q);

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic          hi_i,
  input  logic [7:0]    wdata_i,
  input  logic          mode_we_i,
  input  mode_t         mode_i,
  input  logic          done_i,
  input  logic          masked_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output mode_t         mode_o,
  output logic          tc_o,
  output logic          stop_o
);

  logic [AW-1:0] base_a_q, base_a_d, cur_a_q, cur_a_d;
  logic [AW-1:0] base_c_q, base_c_d, cur_c_q, cur_c_d;
  mode_t         mode_q;
  logic          ack, at_zero, reload;
  logic          a_en, c_en;

  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] old,
                                             input logic hi,
                                             input logic [7:0] b);
    logic [AW-1:0] r;
    r = old;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  always_comb begin
    ack     = done_i & ~masked_i & (mode_q.kind != KIND_CASC) & ~(ld_addr_i | ld_cnt_i);
    at_zero = (cur_c_q == '0);
    tc_o    = ack & at_zero;
    reload  = tc_o & mode_q.autoinit;
    stop_o  = tc_o & ~mode_q.autoinit;
    a_en    = ld_addr_i | ack;
    c_en    = ld_cnt_i | ack;
  end

  always_comb begin
    base_a_d = base_a_q;
    cur_a_d  = cur_a_q;
    if (ld_addr_i) begin
      base_a_d = put_byte(base_a_q, hi_i, wdata_i);
      cur_a_d  = put_byte(cur_a_q, hi_i, wdata_i);
    end else if (reload) begin
      cur_a_d  = base_a_q;
    end else if (ack) begin
      cur_a_d  = mode_q.down ? (cur_a_q - AW'(1)) : (cur_a_q + AW'(1));
    end
  end

  always_comb begin
    base_c_d = base_c_q;
    cur_c_d  = cur_c_q;
    if (ld_cnt_i) begin
      base_c_d = put_byte(base_c_q, hi_i, wdata_i);
      cur_c_d  = put_byte(cur_c_q, hi_i, wdata_i);
    end else if (reload) begin
      cur_c_d  = base_c_q;
    end else if (ack) begin
      cur_c_d  = cur_c_q - AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a_q <= '0;
      cur_a_q  <= '0;
    end else if (a_en) begin
      base_a_q <= base_a_d;
      cur_a_q  <= cur_a_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_c_q <= '0;
      cur_c_q  <= '0;
    end else if (c_en) begin
      base_c_q <= base_c_d;
      cur_c_q  <= cur_c_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (mode_we_i) begin
      mode_q <= mode_i;
    end
  end

  assign addr_o = cur_a_q;
  assign cnt_o  = cur_c_q;
  assign mode_o = mode_q;

  // R3: a terminal transfer without reload leaves an all-ones count
  p_wrap_ffff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && at_zero && !mode_q.autoinit) |=> (cur_c_q == '1));

  // R4: a terminal transfer with reload restores both base copies
  p_reload_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && at_zero && mode_q.autoinit) |=>
      (cur_c_q == $past(base_c_q) && cur_a_q == $past(base_a_q)));

  // R9: a cascade channel never moves without a bus write
  p_cascade_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.kind == KIND_CASC && !ld_addr_i && !ld_cnt_i) |=>
      (cur_c_q == $past(cur_c_q) && cur_a_q == $past(cur_a_q)));

endmodule

// File: rtl/dmac_maskstat.sv
module dmac_maskstat #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           amask_we_i,
  input  logic [NCH-1:0] amask_val_i,
  input  logic           smask_we_i,
  input  logic [CHW-1:0] smask_ch_i,
  input  logic           smask_val_i,
  input  logic           stat_rd_i,
  input  logic [NCH-1:0] tc_i,
  input  logic [NCH-1:0] stop_i,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] tcf_o
);

  logic [NCH-1:0] mask_q, mask_d, tcf_q, tcf_d;
  logic           mask_en, tcf_en;

  always_comb begin
    mask_d = mask_q;
    if (amask_we_i) mask_d = amask_val_i;
    if (smask_we_i) mask_d[smask_ch_i] = smask_val_i;
    mask_d  = mask_d | stop_i;
    mask_en = amask_we_i | smask_we_i | (|stop_i);
  end

  always_comb begin
    tcf_d  = (stat_rd_i ? '0 : tcf_q) | tc_i;
    tcf_en = stat_rd_i | (|tc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcf_q <= '0;
    end else if (tcf_en) begin
      tcf_q <= tcf_d;
    end
  end

  assign mask_o = mask_q;
  assign tcf_o  = tcf_q;

  // R10: a stopping channel is masked on the next cycle
  p_stop_masks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i != '0) |=> ((mask_q & $past(stop_i)) == $past(stop_i)));

  // R5: a status read with no new terminal event empties the flags
  p_stat_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && tc_i == '0) |=> (tcf_q == '0));

  // R5: a new terminal event is never lost
  p_tc_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i != '0) |=> ((tcf_q & $past(tc_i)) == $past(tc_i)));

endmodule

// File: rtl/dmac_regfront.sv
module dmac_regfront
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     io_addr,
  input  logic           io_wr,
  input  logic           io_rd,
  input  logic [7:0]     io_wdata,
  output logic [7:0]     io_rdata,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] xfer_done,
  output logic [NCH-1:0] req_out,
  output logic [NCH-1:0] term_cnt,
  output logic [NCH-1:0] chan_mask,
  output logic [NCH-1:0] chan_dir,
  output logic [2*NCH-1:0] chan_kind
);

  localparam int         CHW     = $clog2(NCH);
  localparam logic [3:0] REG_TOP = 4'(2 * NCH);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  logic           wr_go, rd_go, in_regs, is_cnt, ptr;
  logic [CHW-1:0] sel_ch;
  logic           stat_rd;
  logic [NCH-1:0] ld_addr, ld_cnt, mode_we, tc_v, stop_v, mask_v, tcf_v;
  logic [NCH-1:0][AW-1:0] addr_v, cnt_v;
  mode_t [NCH-1:0] mode_v;
  mode_t           mode_wr;
  logic [AW-1:0]   rd_word;

  always_comb begin
    wr_go   = io_wr;
    rd_go   = io_rd & ~io_wr;
    in_regs = (io_addr < REG_TOP);
    is_cnt  = io_addr[0];
    sel_ch  = io_addr[CHW:1];
    stat_rd = rd_go & (io_addr == A_STAT);
    mode_wr = mode_t'(io_wdata[6:2]);
  end

  dmac_byteptr u_ptr (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .acc_i  ((io_wr | io_rd) & in_regs),
    .clr_i  (wr_go & (io_addr == A_CLRPTR)),
    .ptr_o  (ptr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign ld_addr[i] = wr_go & in_regs & (sel_ch == CHW'(i)) & ~is_cnt;
    assign ld_cnt[i]  = wr_go & in_regs & (sel_ch == CHW'(i)) & is_cnt;
    assign mode_we[i] = wr_go & (io_addr == A_MODE) & (io_wdata[CHW-1:0] == CHW'(i));

    dmac_chan #(.AW(AW)) u_chan (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .ld_addr_i (ld_addr[i]),
      .ld_cnt_i  (ld_cnt[i]),
      .hi_i      (ptr),
      .wdata_i   (io_wdata),
      .mode_we_i (mode_we[i]),
      .mode_i    (mode_wr),
      .done_i    (xfer_done[i]),
      .masked_i  (mask_v[i]),
      .addr_o    (addr_v[i]),
      .cnt_o     (cnt_v[i]),
      .mode_o    (mode_v[i]),
      .tc_o      (tc_v[i]),
      .stop_o    (stop_v[i])
    );

    assign chan_dir[i]         = mode_v[i].dir;
    assign chan_kind[2*i +: 2] = mode_v[i].kind;
  end

  dmac_maskstat #(.NCH(NCH)) u_maskstat (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .amask_we_i  (wr_go & (io_addr == A_AMASK)),
    .amask_val_i (io_wdata[NCH-1:0]),
    .smask_we_i  (wr_go & (io_addr == A_SMASK)),
    .smask_ch_i  (io_wdata[CHW-1:0]),
    .smask_val_i (io_wdata[SMASK_VAL_BIT]),
    .stat_rd_i   (stat_rd),
    .tc_i        (tc_v),
    .stop_i      (stop_v),
    .mask_o      (mask_v),
    .tcf_o       (tcf_v)
  );

  always_comb begin
    rd_word  = is_cnt ? cnt_v[sel_ch] : addr_v[sel_ch];
    io_rdata = '0;
    if (rd_go) begin
      if (in_regs) begin
        io_rdata = ptr ? rd_word[15:8] : rd_word[7:0];
      end else if (io_addr == A_STAT) begin
        io_rdata = 8'({dreq, tcf_v});
      end
    end
  end

  assign req_out   = dreq & ~mask_v;
  assign term_cnt  = tc_v;
  assign chan_mask = mask_v;

endmodule

// File: tb/dmac_regfront_tb_top.sv
module dmac_regfront_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] io_addr;
  logic       io_wr, io_rd;
  logic [7:0] io_wdata, io_rdata;
  logic [3:0] dreq, xfer_done, req_out, term_cnt, chan_mask, chan_dir;
  logic [7:0] chan_kind;

  always #5 clk = ~clk;

  dmac_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .xfer_done(xfer_done),
    .req_out(req_out), .term_cnt(term_cnt), .chan_mask(chan_mask),
    .chan_dir(chan_dir), .chan_kind(chan_kind)
  );

  // bench model
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [4:0]  m_mode[4];   // {kind[1:0], down, autoinit, dir}
  logic [3:0]  m_mask, m_tc;
  logic        m_ptr;
  logic [3:0]  g_dq;
  int          n_vec = 0, n_bad = 0;
  bit          done_flag = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_tc = 0; m_ptr = 0;
  endtask

  function automatic logic [3:0] f_ack(input logic wr, input logic [3:0] a, input logic [3:0] dn);
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = dn[i] && !m_mask[i] && (m_mode[i][4:3] != 2'b10) &&
             !(wr && a < 4'd8 && a[2:1] == 2'(i));
    return r;
  endfunction

  function automatic logic [7:0] f_rdata(input logic wr, input logic rd, input logic [3:0] a, input logic [3:0] dq);
    logic [15:0] w;
    if (!rd || wr) return 8'h00;
    if (a < 4'd8) begin
      w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {dq, m_tc};
    return 8'h00;
  endfunction

  task automatic cyc(input string tag, input logic wr, input logic rd, input logic [3:0] a,
                     input logic [7:0] d, input logic [3:0] dn);
    logic [3:0] ack, tcs, stp;
    logic [7:0] kexp;
    logic [1:0] ch;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; xfer_done = dn; dreq = g_dq;
    #3;
    ack = f_ack(wr, a, dn);
    for (int i = 0; i < 4; i++) begin
      tcs[i] = ack[i] && (m_cc[i] == 16'h0);
      stp[i] = tcs[i] && !m_mode[i][1];
      kexp[2*i +: 2] = m_mode[i][4:3];
    end
    chk(tag, "rdata", 16'(io_rdata), 16'(f_rdata(wr, rd, a, g_dq)));
    chk(tag, "term_cnt", 16'(term_cnt), 16'(tcs));
    chk(tag, "req_out", 16'(req_out), 16'(g_dq & ~m_mask));
    chk(tag, "chan_mask", 16'(chan_mask), 16'(m_mask));
    chk(tag, "chan_dir", 16'(chan_dir), 16'({m_mode[3][0], m_mode[2][0], m_mode[1][0], m_mode[0][0]}));
    chk(tag, "chan_kind", 16'(chan_kind), 16'(kexp));
    // model next state
    for (int i = 0; i < 4; i++) begin
      if (ack[i]) begin
        if (tcs[i] && m_mode[i][1]) begin
          m_ca[i] = m_ba[i]; m_cc[i] = m_bc[i];
        end else begin
          m_cc[i] = m_cc[i] - 16'd1;
          m_ca[i] = m_mode[i][2] ? m_ca[i] - 16'd1 : m_ca[i] + 16'd1;
        end
      end
    end
    if (wr) begin
      if (a < 4'd8) begin
        ch = a[2:1];
        if (a[0]) begin
          if (m_ptr) begin m_bc[ch][15:8] = d; m_cc[ch][15:8] = d; end
          else       begin m_bc[ch][7:0]  = d; m_cc[ch][7:0]  = d; end
        end else begin
          if (m_ptr) begin m_ba[ch][15:8] = d; m_ca[ch][15:8] = d; end
          else       begin m_ba[ch][7:0]  = d; m_ca[ch][7:0]  = d; end
        end
        m_ptr = ~m_ptr;
      end else begin
        case (a)
          4'h9: m_mask[d[1:0]] = d[2];
          4'hA: m_mode[d[1:0]] = d[6:2];
          4'hB: m_ptr = 1'b0;
          4'hC: m_mask = d[3:0];
          default: ;
        endcase
      end
    end else if (rd) begin
      if (a < 4'd8) m_ptr = ~m_ptr;
      else if (a == 4'h8) m_tc = 4'h0;
    end
    m_tc   = m_tc | tcs;
    m_mask = m_mask | stp;
    @(posedge clk);
  endtask

  task automatic wr_op(input string tag, input logic [3:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, 1'b0, a, d, 4'h0);
  endtask
  task automatic rd_op(input string tag, input logic [3:0] a);
    cyc(tag, 1'b0, 1'b1, a, 8'h00, 4'h0);
  endtask
  task automatic dn_op(input string tag, input logic [3:0] dn);
    cyc(tag, 1'b0, 1'b0, 4'hF, 8'h00, dn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; xfer_done = 0; dreq = 0;
    g_dq = 4'h0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R7: reset state
    dn_op("R7", 4'h0);
    rd_op("R7", 4'h0);
    rd_op("R7", 4'h1);
    rd_op("R5", 4'h8);

    // R1: assemble ch1 address and count, read both halves
    wr_op("R2", 4'hB, 8'h5A);
    wr_op("R1", 4'h2, 8'h34); wr_op("R1", 4'h2, 8'h12);
    wr_op("R1", 4'h3, 8'h01); wr_op("R1", 4'h3, 8'h00);
    rd_op("R1", 4'h2); rd_op("R1", 4'h2);
    rd_op("R1", 4'h3); rd_op("R1", 4'h3);

    // R2: half-written value, clear, then read low
    wr_op("R2", 4'h0, 8'hAA);
    wr_op("R2", 4'hB, 8'hFF);
    rd_op("R2", 4'h0);
    wr_op("R2", 4'hB, 8'h00);

    // R8: mode writes per channel
    wr_op("R8", 4'hA, 8'b0_01_0_0_1_10);  // ch2 single, dir=1
    wr_op("R8", 4'hA, 8'b0_00_1_0_0_00);  // ch0 demand, down
    wr_op("R8", 4'hA, 8'b0_00_0_1_0_01);  // ch1 autoinit
    wr_op("R8", 4'hA, 8'b0_10_0_0_0_11);  // ch3 cascade

    // R3: ch0 length 3 (count 2), counting down addresses
    wr_op("R3", 4'h0, 8'h10); wr_op("R3", 4'h0, 8'h00);
    wr_op("R3", 4'h1, 8'h02); wr_op("R3", 4'h1, 8'h00);
    wr_op("R6", 4'h9, 8'h00);               // unmask ch0
    g_dq = 4'b0001;
    dn_op("R3", 4'h1); dn_op("R3", 4'h1); dn_op("R3", 4'h1);
    // R10: ch0 now masked, further strobes ignored
    dn_op("R10", 4'h1);
    rd_op("R3", 4'h1); rd_op("R3", 4'h1);
    rd_op("R3", 4'h0); rd_op("R3", 4'h0);
    // R5: status shows flag then clears
    g_dq = 4'b1010;
    rd_op("R5", 4'h8); rd_op("R5", 4'h8);

    // R4: ch1 autoinit, count 1
    wr_op("R6", 4'h9, 8'h01);
    dn_op("R4", 4'h2); dn_op("R4", 4'h2);
    rd_op("R4", 4'h3); rd_op("R4", 4'h3);
    rd_op("R4", 4'h2); rd_op("R4", 4'h2);
    dn_op("R4", 4'h2);
    // R5: terminal event in same cycle as status read stays set
    cyc("R5", 1'b0, 1'b1, 4'h8, 8'h00, 4'h2);
    cyc("R5", 1'b0, 1'b1, 4'h8, 8'h00, 4'h2);
    rd_op("R5", 4'h8);

    // R6, R7: single and all mask
    wr_op("R6", 4'h9, 8'h06);
    wr_op("R6", 4'h9, 8'h02);
    wr_op("R7", 4'hC, 8'h05);
    wr_op("R7", 4'hC, 8'hF0);

    // R9: cascade ch3 and masked ch2 ignore strobes
    wr_op("R9", 4'hC, 8'h08);             // unmask all but... mask ch3 only
    wr_op("R9", 4'h9, 8'h03);             // unmask ch3
    wr_op("R9", 4'h9, 8'h06);             // mask ch2
    dn_op("R9", 4'hC); dn_op("R9", 4'hC);
    rd_op("R9", 4'h7); rd_op("R9", 4'h7);
    rd_op("R9", 4'h5); rd_op("R9", 4'h5);

    // R11: write collides with a strobe on the same channel
    wr_op("R11", 4'h9, 8'h00);
    wr_op("R11", 4'h1, 8'h05);
    cyc("R11", 1'b1, 1'b0, 4'h1, 8'h00, 4'h1);
    rd_op("R11", 4'h1); rd_op("R11", 4'h1);

    // R10: terminal stop beats same-cycle unmask
    wr_op("R10", 4'h1, 8'h00); wr_op("R10", 4'h1, 8'h00);
    cyc("R10", 1'b1, 1'b0, 4'hC, 8'h00, 4'h1);
    dn_op("R10", 4'h0);

    // R12: both strobes, unused reads and writes
    cyc("R12", 1'b1, 1'b1, 4'h4, 8'h77, 4'h0);
    rd_op("R12", 4'hD); rd_op("R12", 4'h9);
    wr_op("R12", 4'hE, 8'hFF); wr_op("R12", 4'h8, 8'hFF);
    rd_op("R12", 4'h4); rd_op("R12", 4'h4);

    // constrained random mix
    void'($urandom(32'd4242));
    for (int k = 0; k < 6000; k++) begin
      logic [3:0] a, dn;
      logic [7:0] d;
      logic wr, rd;
      int sel;
      sel = int'($urandom % 10);
      a   = 4'($urandom);
      d   = 8'($urandom);
      dn  = 4'($urandom);
      g_dq = 4'($urandom);
      wr = (sel < 4); rd = (sel >= 3 && sel < 7);
      if (sel == 9) begin a = 4'hC; d = 8'h00; wr = 1; rd = 0; end
      if (a < 4'd8 && wr && ($urandom % 2 == 0)) d = 8'($urandom % 4);
      cyc("random", wr, rd, a, d, dn);
    end

    cyc("idle", 1'b0, 1'b0, 4'h0, 8'h00, 4'h0);
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule